// File: doc/BRIEF.md
# Segment Address Translator

This unit turns a segment selector value and an offset into a linear address. It works in one of two modes, chosen for each request. In real mode it shifts a 16-bit segment value left by four bits and adds the low 16 bits of the offset, which gives a 20-bit address that wraps within 1 MB. In protected mode it adds a full 32-bit offset to the base held in a descriptor register. It also checks the offset against the segment size, which is the descriptor limit counted in 4096-byte units.

A request is presented for one cycle with `in_valid` high. The result appears on the registered outputs on the following cycle, with `out_valid` high and a fault flag. A protected-mode request whose offset lies outside the segment, or whose descriptor is marked not present, reports a fault and returns address zero. Between requests the outputs hold their last result.

Top module: `seg_xlate`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R2: In real mode (`in_mode` = 0) the address is `(in_seg * 16 + in_off[15:0]) mod 2^20`, with bits 31..20 of `out_addr` zero. For example, 08F1h:0100h gives 09010h and 028Fh:0030h gives 02920h.
- R3: A real-mode sum that reaches 2^20 wraps. FFFFh:0010h gives 00000h, and F000h:FFFFh gives FFFFFh.
- R4: In real mode `out_fault` is 0, and neither the descriptor inputs nor `in_off[31:16]` change the result.
- R5: In protected mode (`in_mode` = 1) with no fault, the address is `(desc_base + in_off) mod 2^32`.
- R6: In protected mode the unit faults when `in_off >= desc_limit * 4096`, which is the same as `in_off[31:12] >= desc_limit`. A limit of 0 faults on every offset.
- R7: In protected mode the unit faults when present bit 7 of `desc_access` is 0, whatever the offset.
- R8: When `out_fault` is 1, `out_addr` is zero.
- R9: While `rst_n` is low at a clock edge, `out_valid`, `out_fault` and `out_addr` are cleared to 0.
- R10: In a cycle after `in_valid` is low, `out_addr` and `out_fault` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 1 | 0 = real mode, 1 = protected mode |
| in_seg | input | 16 | Segment value (real mode) |
| in_off | input | 32 | Offset; real mode uses bits 15..0 only |
| desc_base | input | 32 | Descriptor base address |
| desc_limit | input | 20 | Descriptor limit in 4096-byte units |
| desc_access | input | 8 | Descriptor access field; bit 7 = present |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_addr | output | 32 | Linear address, zero on fault |
| out_fault | output | 1 | Limit or not-present fault |

## Verification
Real mode is tested with the two worked segment:offset pairs and with sums that land exactly on and just below the 1 MB wrap point. A repeat of one pair with garbage in the upper offset bits and in the descriptor shows that those inputs are ignored. Protected mode is tested with offsets one byte either side of a one-page limit, with a zero limit, with the largest offset against the largest limit, and with a base-plus-offset sum that wraps past 4 GB. Together these separate an inclusive comparison from an exclusive one and a byte-granular limit from a page-granular one. Back-to-back requests and idle gaps show that results line up with their requests and that the outputs hold between requests.

// File: rtl/seg_xlate_pkg.sv
// Package: shared types for the segment address translator.
// Assumes: a single mode bit selects the translation rule.
package seg_xlate_pkg;
    typedef enum logic {
        MODE_REAL = 1'b0,
        MODE_PROT = 1'b1
    } xl_mode_e;
endpackage

// File: rtl/seg_real_calc.sv
// Real-mode address former: shifts the segment left and adds the offset.
// Assumes: REAL_ADDR_W >= SEG_W, and the offset is as wide as the segment.
// A carry beyond REAL_ADDR_W bits is discarded (wrap within the space).
module seg_real_calc #(
    parameter int SEG_W       = 16,
    parameter int REAL_ADDR_W = 20
) (
    input  logic [SEG_W-1:0]       seg,
    input  logic [SEG_W-1:0]       off,
    output logic [REAL_ADDR_W-1:0] lin
);
    localparam int SHIFT = REAL_ADDR_W - SEG_W;
    localparam int SUM_W = REAL_ADDR_W + 1;

    logic [SUM_W-1:0] sum;

    // Purpose: shifted segment plus zero-extended offset, then truncate.
    always_comb begin
        sum = {1'b0, seg, {SHIFT{1'b0}}} + {{(SUM_W-SEG_W){1'b0}}, off};
        lin = sum[REAL_ADDR_W-1:0];
    end
endmodule

// File: rtl/seg_prot_calc.sv
// Protected-mode address former: base plus offset, with a page-granular
// limit check and a present-bit check.
// Assumes: the limit counts pages of 2^(ADDR_W-LIMIT_W) bytes.
module seg_prot_calc #(
    parameter int ADDR_W      = 32,
    parameter int LIMIT_W     = 20,
    parameter int ACC_W       = 8,
    parameter int PRESENT_BIT = 7
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [LIMIT_W-1:0] limit,
    input  logic [ACC_W-1:0]   access,
    input  logic [ADDR_W-1:0]  off,
    output logic [ADDR_W-1:0]  lin,
    output logic               fault
);
    localparam int PAGE_SHIFT = ADDR_W - LIMIT_W;

    logic over_limit;
    logic absent;

    // Purpose: the offset page index must stay below the limit.
    always_comb over_limit = off[ADDR_W-1:PAGE_SHIFT] >= limit;

    // Purpose: decode the present flag from the access field.
    always_comb absent = ~access[PRESENT_BIT];

    // Purpose: form the address and merge the fault causes.
    always_comb begin
        lin   = base + off;
        fault = over_limit | absent;
    end
endmodule

// File: rtl/seg_xlate.sv
// Segment address translator top: picks real or protected translation per
// request and registers address, fault and valid one cycle later.
// Assumes: synchronous active-low reset; outputs hold while idle.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W       = 16,
    parameter int REAL_ADDR_W = 20,
    parameter int ADDR_W      = 32,
    parameter int LIMIT_W     = 20,
    parameter int ACC_W       = 8,
    parameter int PRESENT_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [SEG_W-1:0]  in_seg,
    input  logic [ADDR_W-1:0] in_off,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [LIMIT_W-1:0] desc_limit,
    input  logic [ACC_W-1:0]  desc_access,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_fault
);
    localparam int PAD_W = ADDR_W - REAL_ADDR_W;

    xl_mode_e              mode;
    logic [REAL_ADDR_W-1:0] real_lin;
    logic [ADDR_W-1:0]     prot_lin;
    logic                  prot_fault;
    logic [ADDR_W-1:0]     sel_addr;
    logic                  sel_fault;

    // Purpose: give the mode bit its enumerated meaning.
    always_comb mode = xl_mode_e'(in_mode);

    seg_real_calc #(
        .SEG_W       (SEG_W),
        .REAL_ADDR_W (REAL_ADDR_W)
    ) u_real (
        .seg (in_seg),
        .off (in_off[SEG_W-1:0]),
        .lin (real_lin)
    );

    seg_prot_calc #(
        .ADDR_W      (ADDR_W),
        .LIMIT_W     (LIMIT_W),
        .ACC_W       (ACC_W),
        .PRESENT_BIT (PRESENT_BIT)
    ) u_prot (
        .base   (desc_base),
        .limit  (desc_limit),
        .access (desc_access),
        .off    (in_off),
        .lin    (prot_lin),
        .fault  (prot_fault)
    );

    // Purpose: select the result of the active mode; a fault zeroes the address.
    always_comb begin
        if (mode == MODE_PROT) begin
            sel_fault = prot_fault;
            sel_addr  = prot_fault ? '0 : prot_lin;
        end else begin
            sel_fault = 1'b0;
            sel_addr  = {{PAD_W{1'b0}}, real_lin};
        end
    end

    // Purpose: register the result one cycle after a request, hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_fault <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr  <= sel_addr;
                out_fault <= sel_fault;
            end
        end
    end

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_real_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode) |=> (out_addr[ADDR_W-1:REAL_ADDR_W] == '0));
    a_r4_real_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode) |=> !out_fault);
    a_r7_absent_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode && !desc_access[PRESENT_BIT]) |=> out_fault);
    a_r8_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_addr == '0));
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_addr) && $stable(out_fault)));
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
    typedef struct {
        logic [31:0] addr;
        logic        fault;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [15:0] in_seg = '0;
    logic [31:0] in_off = '0;
    logic [31:0] desc_base = '0;
    logic [19:0] desc_limit = '0;
    logic [7:0]  desc_access = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_fault;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    seg_xlate uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_seg(in_seg), .in_off(in_off), .desc_base(desc_base),
        .desc_limit(desc_limit), .desc_access(desc_access),
        .out_valid(out_valid), .out_addr(out_addr), .out_fault(out_fault)
    );

    task automatic check(string tag, logic [32:0] act, logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic mode, logic [15:0] seg, logic [31:0] off,
                         logic [31:0] base, logic [19:0] lim, logic [7:0] acc,
                         string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_mode = mode; in_seg = seg; in_off = off;
        desc_base = base; desc_limit = lim; desc_access = acc;
        if (!mode) begin
            e.addr  = {12'h000, 20'(({4'h0, seg, 4'h0}) + {8'h00, off[15:0]})};
            e.fault = 1'b0;
        end else begin
            e.fault = !acc[7] || ({12'h000, off[31:12]} >= {12'h000, lim});
            e.addr  = e.fault ? 32'h0 : base + off;
        end
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_seg = 16'hDEAD; in_off = 32'h1234_5678;
        end
    endtask

    // Monitor: pop the oldest expectation whenever a result appears.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check("R1 unexpected out_valid", {32'h0, out_valid}, 33'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " addr"}, {1'b0, out_addr}, {1'b0, e.addr});
                check({e.tag, " fault"}, {32'h0, out_fault}, {32'h0, e.fault});
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", {32'h0, out_valid}, 33'h0);
        check("R9 reset out_addr", {1'b0, out_addr}, 33'h0);
        check("R9 reset out_fault", {32'h0, out_fault}, 33'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 worked pairs, back to back
        drive(1'b0, 16'h08F1, 32'h0000_0100, 32'h0, 20'h0, 8'h0, "R2 08F1:0100");
        drive(1'b0, 16'h028F, 32'h0000_0030, 32'h0, 20'h0, 8'h0, "R2 028F:0030");
        idle(1);
        // R1: idle cycle gives no valid
        @(negedge clk);
        check("R1 idle out_valid", {32'h0, out_valid}, 33'h0);
        // R4: upper offset bits and descriptor ignored in real mode
        drive(1'b0, 16'h028F, 32'hABCD_0030, 32'hFFFF_FFFF, 20'h0, 8'h00, "R4 junk ignored");
        // R3 wrap
        drive(1'b0, 16'hFFFF, 32'h0000_0010, 32'h0, 20'h0, 8'h0, "R3 wrap to zero");
        drive(1'b0, 16'hF000, 32'h0000_FFFF, 32'h0, 20'h0, 8'h0, "R3 top of space");
        // R5 protected
        drive(1'b1, 16'h0, 32'h0000_0100, 32'h0000_3000, 20'h2, 8'h80, "R5 base plus off");
        drive(1'b1, 16'h0, 32'h0000_2000, 32'hFFFF_F000, 20'hFFFFF, 8'h80, "R5 wrap 4G");
        // R6 limit boundaries
        drive(1'b1, 16'h0, 32'h0000_0FFF, 32'h0002_6000, 20'h1, 8'h80, "R6 last byte ok");
        drive(1'b1, 16'h0, 32'h0000_1000, 32'h0002_6000, 20'h1, 8'h80, "R6 first byte out");
        drive(1'b1, 16'h0, 32'h0000_0000, 32'h0002_6000, 20'h0, 8'h80, "R6 zero limit");
        drive(1'b1, 16'h0, 32'hFFFF_FFFF, 32'h0, 20'hFFFFF, 8'h80, "R6 max offset");
        // R7 not present, R8 fault zeroes address
        drive(1'b1, 16'h0, 32'h0000_0010, 32'h0000_5000, 20'h10, 8'h7F, "R7 not present");
        drive(1'b1, 16'h0, 32'h0000_0040, 32'h0000_5000, 20'h10, 8'h80, "R5 present ok");
        drive(1'b1, 16'h0, 32'h0001_0000, 32'h0000_5000, 20'h10, 8'hFF, "R8 fault addr zero");
        idle(1);
        @(negedge clk);
        held = out_addr;
        check("R8 fault flag before idle", {32'h0, out_fault}, 33'h1);
        idle(2);
        @(negedge clk);
        check("R10 addr held", {1'b0, out_addr}, {1'b0, held});
        check("R10 fault held", {32'h0, out_fault}, 33'h1);
        check("R1 queue drained", {1'b0, 32'(sb.size())}, 33'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule